// File: doc/BRIEF.md
# Exception and Interrupt Vector Dispatcher

This block sits beside an execution core and resolves two kinds of events: exceptions that the core raises (divide by zero, page fault, a user-invoked exception, illegal instruction) and software interrupt requests that name an interrupt number. For each accepted event it scans a table of 64-bit vector entries through a read port with one cycle of latency. It looks for the first well-formed entry that serves the event. The scan stops at the first all-zero entry or at the end of the table.

The result arrives as a one-cycle outcome pulse. The outcome is one of three things. It can be a jump to the handler offset of the entry. It can be a resume at the faulting address, used when a user-invoked exception has no handler. Or it can be a sticky hang. Exceptions also produce writes to the core's first two general registers: the faulting execution address always goes to r0, and for a page fault the accessed address goes to r1. No other register is written. A user-mode request that targets an externally-callable-only entry, or a request whose number has no entry, becomes an illegal-instruction exception. While a handler is active an in-exception bit is held. A further exception in that state goes straight to the hang without any register writes. The core drops the bit with a return strobe.

Top module: `vec_dispatch`

## Requirements
- R1: A table word is laid out as ID in bits 63:56, flags in bits 55:48 and handler offset in bits 47:0. A jump outcome (kind 1) drives the target with the offset zero-extended to 64 bits.
- R2: Exception codes are 0 (divide), 1 (page fault), 2 (user-invoked) and 3 (illegal instruction), and any code above 3 is handled as 3. The handler for exception c is an entry with flag bit 0 (exception) set, ID equal to c, and flag bit 1 (user) set exactly when c is 2.
- R3: Every exception outcome except the nested hang pulses r0 write with the faulting address. A page fault also pulses r1 write with the accessed address, and no other exception writes r1.
- R4: An entry with any of flag bits 6 to 2 set, or with the user bit set while the exception bit is clear, is skipped and never serves an event.
- R5: The scan ends at the first all-zero entry, so entries behind it are never used. It also ends after the last of DEPTH entries.
- R6: An interrupt request is served by the entry with the exception bit clear and ID equal to the request number. The outcome is a jump to its offset, with no register writes and no change of the in-exception bit.
- R7: A user-mode request to an entry with flag bit 7 (external only) set becomes an illegal-instruction exception at the request's address. The same request in kernel mode dispatches normally.
- R8: An interrupt request with no serving entry becomes an illegal-instruction exception at the request's address.
- R9: A user-invoked exception without a handler writes r0 and gives a resume outcome (kind 2) whose target is the faulting address, with no hang.
- R10: Any other exception without a handler writes its registers and gives a hang outcome (kind 3). Hang then stays high and event ready stays low until reset.
- R11: Dispatching an exception to a handler sets the in-exception output, and the return strobe clears it. An exception while it is set gives a hang outcome with no register writes.
- R12: After reset, ready is high and hang, in-exception, outcome valid and both register writes are low.
- R13: When several entries serve an event, the one at the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event accepted when high together with evt_valid |
| evt_is_exc | input | 1 | 1 for an exception, 0 for an interrupt request |
| evt_code | input | 8 | Exception code or interrupt number |
| evt_pc | input | 64 | Faulting or requesting execution address |
| evt_addr | input | 64 | Accessed address (page fault) |
| evt_user | input | 1 | Requester runs in user mode |
| exc_ret | input | 1 | Handler return strobe, clears in-exception |
| tbl_rd | output | 1 | Table read strobe |
| tbl_idx | output | IDX_W | Table entry index |
| tbl_data | input | 64 | Entry read, valid the cycle after tbl_rd |
| out_valid | output | 1 | Outcome pulse |
| out_kind | output | 2 | 1 jump, 2 resume, 3 hang |
| out_target | output | 64 | Jump or resume address |
| r0_we | output | 1 | Write strobe for r0 |
| r0_wdata | output | 64 | Value for r0 |
| r1_we | output | 1 | Write strobe for r1 |
| r1_wdata | output | 64 | Value for r1 |
| in_exc | output | 1 | In-exception control bit |
| hang | output | 1 | Core hung |

## Verification
A scan that kept a wrong index or a stale match shows up in the outcome pulse of the same event: the jump target names a different entry, or the outcome kind flips between jump, resume and hang. This can be seen within a few cycles per scanned entry. A wrong in-exception or hang state shows up only on the next event: a handler dispatch turns into a hang with no r0 write, or ready stays low. For this reason the directed scenarios chain two events where the state matters. Register-write mistakes are visible in the same cycle as the outcome pulse.

// File: rtl/vd_pkg.sv
package vd_pkg;
  localparam int unsigned VD_WORD_W = 64;
  localparam int unsigned VD_OFF_W  = 48;
  localparam int unsigned FLG_EXT   = 7;
  localparam int unsigned FLG_USR   = 1;
  localparam int unsigned FLG_EXC   = 0;

  localparam logic [7:0] EXC_DIV  = 8'd0;
  localparam logic [7:0] EXC_PAGE = 8'd1;
  localparam logic [7:0] EXC_USER = 8'd2;
  localparam logic [7:0] EXC_ILL  = 8'd3;

  typedef struct packed {
    logic [7:0]          id;
    logic [7:0]          flags;
    logic [VD_OFF_W-1:0] offset;
  } vd_entry_t;

  typedef enum logic [1:0] {
    VD_NONE   = 2'd0,
    VD_JUMP   = 2'd1,
    VD_RESUME = 2'd2,
    VD_HANG   = 2'd3
  } vd_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_RD, S_EV, S_HOLD
  } vd_state_e;

  function automatic logic entry_is_null(vd_entry_t e);
    return e == '0;
  endfunction

  function automatic logic entry_well_formed(vd_entry_t e);
    return (e.flags[6:2] == 5'd0) && !(e.flags[FLG_USR] && !e.flags[FLG_EXC]);
  endfunction

  function automatic logic entry_serves(vd_entry_t e, logic want_exc, logic [7:0] num);
    if (!entry_well_formed(e) || e.id != num) return 1'b0;
    if (want_exc)
      return e.flags[FLG_EXC] && (e.flags[FLG_USR] == (num == EXC_USER));
    return !e.flags[FLG_EXC];
  endfunction

  function automatic logic [7:0] norm_exc_code(logic [7:0] c);
    return (c > EXC_ILL) ? EXC_ILL : c;
  endfunction

  function automatic logic [VD_WORD_W-1:0] offset_to_target(vd_entry_t e);
    return {{(VD_WORD_W-VD_OFF_W){1'b0}}, e.offset};
  endfunction
endpackage

// File: rtl/vd_entry_match.sv
module vd_entry_match
  import vd_pkg::*;
(
  input  logic [VD_WORD_W-1:0] raw,
  input  logic                 want_exc,
  input  logic [7:0]           num,
  output logic                 is_null,
  output logic                 hit,
  output logic                 ext
);
  vd_entry_t e;
  assign e       = vd_entry_t'(raw);
  assign is_null = entry_is_null(e);
  assign hit     = entry_serves(e, want_exc, num);
  assign ext     = e.flags[FLG_EXT];
endmodule

// File: rtl/vd_scan_ctrl.sv
module vd_scan_ctrl
  import vd_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned IDX_W = 5
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_valid,
  output logic                 evt_ready,
  input  logic                 evt_is_exc,
  input  logic [7:0]           evt_code,
  input  logic [VD_WORD_W-1:0] evt_pc,
  input  logic [VD_WORD_W-1:0] evt_addr,
  input  logic                 evt_user,
  input  logic                 in_exc,
  input  logic                 hang,
  output logic                 tbl_rd,
  output logic [IDX_W-1:0]     tbl_idx,
  input  logic [VD_WORD_W-1:0] tbl_data,
  output logic                 res_valid,
  output logic                 res_nested,
  output logic                 res_hit,
  output vd_entry_t            res_entry,
  output logic                 res_exc,
  output logic [7:0]           res_code,
  output logic [VD_WORD_W-1:0] res_pc,
  output logic [VD_WORD_W-1:0] res_addr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  vd_state_e            state;
  logic [IDX_W-1:0]     idx;
  logic                 cur_exc, cur_user;
  logic [7:0]           cur_code;
  logic [VD_WORD_W-1:0] cur_pc, cur_addr;

  logic m_null, m_hit, m_ext;
  logic accept, nested, scan_hit, scan_miss, need_reroute;

  vd_entry_match u_match (
    .raw      (tbl_data),
    .want_exc (cur_exc),
    .num      (cur_code),
    .is_null  (m_null),
    .hit      (m_hit),
    .ext      (m_ext)
  );

  assign evt_ready    = (state == S_IDLE) && !hang;
  assign accept       = evt_valid && evt_ready;
  assign tbl_rd       = (state == S_RD);
  assign tbl_idx      = idx;
  assign nested       = (state == S_START) && cur_exc && in_exc;
  assign scan_hit     = (state == S_EV) && !m_null && m_hit;
  assign scan_miss    = (state == S_EV) && (m_null || (!m_hit && idx == LAST_IDX));
  assign need_reroute = !cur_exc && ((scan_hit && cur_user && m_ext) || scan_miss);

  assign res_valid  = nested || ((scan_hit || scan_miss) && !need_reroute);
  assign res_nested = nested;
  assign res_hit    = scan_hit;
  assign res_entry  = vd_entry_t'(tbl_data);
  assign res_exc    = cur_exc;
  assign res_code   = cur_code;
  assign res_pc     = cur_pc;
  assign res_addr   = cur_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      cur_exc  <= 1'b0;
      cur_user <= 1'b0;
      cur_code <= '0;
      cur_pc   <= '0;
      cur_addr <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state    <= S_START;
          cur_exc  <= evt_is_exc;
          cur_code <= evt_is_exc ? norm_exc_code(evt_code) : evt_code;
          cur_pc   <= evt_pc;
          cur_addr <= evt_addr;
          cur_user <= evt_user;
        end
        S_START: begin
          idx   <= '0;
          state <= nested ? S_HOLD : S_RD;
        end
        S_RD: state <= S_EV;
        S_EV: begin
          if (need_reroute) begin
            cur_exc  <= 1'b1;
            cur_code <= EXC_ILL;
            state    <= S_START;
          end else if (res_valid) begin
            state <= S_HOLD;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_RD;
          end
        end
        S_HOLD:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5: each read is followed by an evaluation cycle, never a back-to-back read
  assert_read_then_eval_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd |=> !tbl_rd);

  // R2: one resolution per accepted event
  assert_single_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R5: an all-zero entry never resolves as a hit
  assert_null_not_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (res_entry != '0));
endmodule

// File: rtl/vd_outcome.sv
module vd_outcome
  import vd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 res_valid,
  input  logic                 res_nested,
  input  logic                 res_hit,
  input  vd_entry_t            res_entry,
  input  logic                 res_exc,
  input  logic [7:0]           res_code,
  input  logic [VD_WORD_W-1:0] res_pc,
  input  logic [VD_WORD_W-1:0] res_addr,
  input  logic                 exc_ret,
  output logic                 out_valid,
  output vd_kind_e             out_kind,
  output logic [VD_WORD_W-1:0] out_target,
  output logic                 r0_we,
  output logic [VD_WORD_W-1:0] r0_wdata,
  output logic                 r1_we,
  output logic [VD_WORD_W-1:0] r1_wdata,
  output logic                 in_exc,
  output logic                 hang
);
  vd_kind_e             nx_kind;
  logic [VD_WORD_W-1:0] nx_target;
  logic                 nx_w0, nx_w1, set_inexc, set_hang;

  always_comb begin
    nx_kind   = VD_NONE;
    nx_target = '0;
    nx_w0     = 1'b0;
    nx_w1     = 1'b0;
    set_inexc = 1'b0;
    if (res_valid) begin
      if (res_nested) begin
        nx_kind = VD_HANG;
      end else if (res_exc) begin
        nx_w0 = 1'b1;
        nx_w1 = (res_code == EXC_PAGE);
        if (res_hit) begin
          nx_kind   = VD_JUMP;
          nx_target = offset_to_target(res_entry);
          set_inexc = 1'b1;
        end else if (res_code == EXC_USER) begin
          nx_kind   = VD_RESUME;
          nx_target = res_pc;
        end else begin
          nx_kind = VD_HANG;
        end
      end else begin
        nx_kind   = VD_JUMP;
        nx_target = offset_to_target(res_entry);
      end
    end
  end

  assign set_hang = res_valid && (nx_kind == VD_HANG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_kind   <= VD_NONE;
      out_target <= '0;
      r0_we      <= 1'b0;
      r0_wdata   <= '0;
      r1_we      <= 1'b0;
      r1_wdata   <= '0;
      in_exc     <= 1'b0;
      hang       <= 1'b0;
    end else begin
      out_valid  <= res_valid;
      out_kind   <= nx_kind;
      out_target <= nx_target;
      r0_we      <= nx_w0;
      r0_wdata   <= nx_w0 ? res_pc : '0;
      r1_we      <= nx_w1;
      r1_wdata   <= nx_w1 ? res_addr : '0;
      if (set_hang) hang <= 1'b1;
      if (set_inexc)    in_exc <= 1'b1;
      else if (exc_ret) in_exc <= 1'b0;
    end
  end

  // R3: r1 is only written alongside r0
  assert_r1_with_r0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    r1_we |-> r0_we);

  // R3: register writes only accompany an outcome pulse
  assert_write_on_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
    r0_we |-> out_valid);

  // R10: hang never drops without reset
  assert_hang_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hang |=> hang);

  // R10: a hang outcome is accompanied by the hang level
  assert_hang_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == VD_HANG) |-> hang);

  // R11: a nested exception hangs without register writes
  assert_nested_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_nested) |=> (out_kind == VD_HANG && !r0_we && !r1_we));

  // R1: jump targets carry a zero upper part
  assert_jump_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == VD_JUMP) |-> (out_target[VD_WORD_W-1:VD_OFF_W] == '0));
endmodule

// File: rtl/vec_dispatch.sv
module vec_dispatch
  import vd_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic              evt_is_exc,
  input  logic [7:0]        evt_code,
  input  logic [63:0]       evt_pc,
  input  logic [63:0]       evt_addr,
  input  logic              evt_user,
  input  logic              exc_ret,
  output logic              tbl_rd,
  output logic [IDX_W-1:0]  tbl_idx,
  input  logic [63:0]       tbl_data,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [63:0]       out_target,
  output logic              r0_we,
  output logic [63:0]       r0_wdata,
  output logic              r1_we,
  output logic [63:0]       r1_wdata,
  output logic              in_exc,
  output logic              hang
);
  logic                 res_valid, res_nested, res_hit, res_exc;
  vd_entry_t            res_entry;
  logic [7:0]           res_code;
  logic [VD_WORD_W-1:0] res_pc, res_addr;
  vd_kind_e             kind;

  vd_scan_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .evt_ready  (evt_ready),
    .evt_is_exc (evt_is_exc),
    .evt_code   (evt_code),
    .evt_pc     (evt_pc),
    .evt_addr   (evt_addr),
    .evt_user   (evt_user),
    .in_exc     (in_exc),
    .hang       (hang),
    .tbl_rd     (tbl_rd),
    .tbl_idx    (tbl_idx),
    .tbl_data   (tbl_data),
    .res_valid  (res_valid),
    .res_nested (res_nested),
    .res_hit    (res_hit),
    .res_entry  (res_entry),
    .res_exc    (res_exc),
    .res_code   (res_code),
    .res_pc     (res_pc),
    .res_addr   (res_addr)
  );

  vd_outcome u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .res_nested (res_nested),
    .res_hit    (res_hit),
    .res_entry  (res_entry),
    .res_exc    (res_exc),
    .res_code   (res_code),
    .res_pc     (res_pc),
    .res_addr   (res_addr),
    .exc_ret    (exc_ret),
    .out_valid  (out_valid),
    .out_kind   (kind),
    .out_target (out_target),
    .r0_we      (r0_we),
    .r0_wdata   (r0_wdata),
    .r1_we      (r1_we),
    .r1_wdata   (r1_wdata),
    .in_exc     (in_exc),
    .hang       (hang)
  );

  assign out_kind = kind;

  // R10: no event is taken once hung
  assert_no_accept_hung_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hang) |-> !evt_ready);
endmodule

// File: tb/vec_dispatch_bench.sv
module vec_dispatch_bench;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0, evt_is_exc = 1'b0, evt_user = 1'b0, exc_ret = 1'b0;
  logic [7:0]  evt_code = '0;
  logic [63:0] evt_pc = '0, evt_addr = '0;
  logic        evt_ready, tbl_rd, out_valid, r0_we, r1_we, in_exc, hang;
  logic [4:0]  tbl_idx;
  logic [63:0] tbl_data = '0;
  logic [1:0]  out_kind;
  logic [63:0] out_target, r0_wdata, r1_wdata;

  logic [63:0] tbl_mem [DEPTH];

  int n_chk = 0, n_fail = 0;
  logic        g_valid, g_r0we, g_r1we;
  logic [1:0]  g_kind;
  logic [63:0] g_target, g_r0, g_r1;

  always #5 clk = ~clk;

  always @(posedge clk) if (tbl_rd) tbl_data <= tbl_mem[tbl_idx];

  vec_dispatch #(.DEPTH(DEPTH)) u_vec_dispatch (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_is_exc(evt_is_exc), .evt_code(evt_code), .evt_pc(evt_pc),
    .evt_addr(evt_addr), .evt_user(evt_user), .exc_ret(exc_ret),
    .tbl_rd(tbl_rd), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
    .out_valid(out_valid), .out_kind(out_kind), .out_target(out_target),
    .r0_we(r0_we), .r0_wdata(r0_wdata), .r1_we(r1_we), .r1_wdata(r1_wdata),
    .in_exc(in_exc), .hang(hang)
  );

  function automatic logic [63:0] ent(logic [7:0] id, logic [7:0] fl, logic [47:0] off);
    return {id, fl, off};
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clear_table();
    for (int i = 0; i < DEPTH; i++) tbl_mem[i] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; evt_valid = 1'b0; exc_ret = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ret_pulse();
    @(negedge clk); exc_ret = 1'b1;
    @(negedge clk); exc_ret = 1'b0;
  endtask

  task automatic fire(logic is_exc, logic [7:0] code, logic [63:0] pc,
                      logic [63:0] addr, logic user);
    int n;
    @(negedge clk);
    n = 0;
    while (!evt_ready && n < 200) begin @(negedge clk); n++; end
    evt_valid = 1'b1; evt_is_exc = is_exc; evt_code = code;
    evt_pc = pc; evt_addr = addr; evt_user = user;
    @(negedge clk);
    evt_valid = 1'b0;
    n = 0;
    while (!out_valid && n < 500) begin @(negedge clk); n++; end
    g_valid = out_valid; g_kind = out_kind; g_target = out_target;
    g_r0we = r0_we; g_r0 = r0_wdata; g_r1we = r1_we; g_r1 = r1_wdata;
    if (!g_valid) begin
      n_chk++; n_fail++;
      $display("FAIL outcome timeout: got 0 expected 1");
    end
  endtask

  task automatic t_reset();
    check("R12 ready", 64'(evt_ready), 64'd1);
    check("R12 hang", 64'(hang), 64'd0);
    check("R12 in_exc", 64'(in_exc), 64'd0);
    check("R12 out_valid", 64'(out_valid), 64'd0);
    check("R12 r0_we", 64'(r0_we), 64'd0);
  endtask

  task automatic t_int_jump();
    clear_table();
    tbl_mem[0] = ent(8'h05, 8'h01, 48'h111);
    tbl_mem[1] = ent(8'h21, 8'h00, 48'hABCDEF012345);
    fire(1'b0, 8'h21, 64'h1000, 64'h0, 1'b0);
    check("R6 kind", 64'(g_kind), 64'd1);
    check("R1 target", g_target, 64'h0000ABCDEF012345);
    check("R6 no r0", 64'(g_r0we), 64'd0);
    check("R6 no r1", 64'(g_r1we), 64'd0);
    check("R6 in_exc", 64'(in_exc), 64'd0);
  endtask

  task automatic t_div_handler();
    clear_table();
    tbl_mem[0] = ent(8'h00, 8'h01, 48'h400);
    fire(1'b1, 8'h00, 64'h2222, 64'h9, 1'b0);
    check("R2 kind", 64'(g_kind), 64'd1);
    check("R2 target", g_target, 64'h400);
    check("R3 r0_we", 64'(g_r0we), 64'd1);
    check("R3 r0", g_r0, 64'h2222);
    check("R3 no r1", 64'(g_r1we), 64'd0);
    check("R11 set", 64'(in_exc), 64'd1);
    ret_pulse();
    check("R11 clear", 64'(in_exc), 64'd0);
  endtask

  task automatic t_page();
    clear_table();
    tbl_mem[0] = ent(8'h01, 8'h01, 48'h800);
    fire(1'b1, 8'h01, 64'h3000, 64'hDEADBEEF0000, 1'b0);
    check("R3 page target", g_target, 64'h800);
    check("R3 page r0", g_r0, 64'h3000);
    check("R3 page r1_we", 64'(g_r1we), 64'd1);
    check("R3 page r1", g_r1, 64'hDEADBEEF0000);
    ret_pulse();
  endtask

  task automatic t_priority();
    clear_table();
    tbl_mem[0] = ent(8'h30, 8'h00, 48'h111);
    tbl_mem[1] = ent(8'h30, 8'h00, 48'h222);
    fire(1'b0, 8'h30, 64'h10, 64'h0, 1'b0);
    check("R13 first wins", g_target, 64'h111);
  endtask

  task automatic t_malformed();
    clear_table();
    tbl_mem[0] = ent(8'h31, 8'h08, 48'h111);
    tbl_mem[1] = ent(8'h31, 8'h02, 48'h222);
    tbl_mem[2] = ent(8'h31, 8'h00, 48'h333);
    fire(1'b0, 8'h31, 64'h20, 64'h0, 1'b0);
    check("R4 skip malformed", g_target, 64'h333);
  endtask

  task automatic t_null_stop();
    clear_table();
    tbl_mem[0] = ent(8'h03, 8'h01, 48'h900);
    tbl_mem[2] = ent(8'h40, 8'h00, 48'h555);
    fire(1'b0, 8'h40, 64'h4444, 64'h0, 1'b0);
    check("R5 null stop target", g_target, 64'h900);
    check("R5 null stop r0", g_r0, 64'h4444);
    ret_pulse();
  endtask

  task automatic t_depth_miss();
    for (int i = 0; i < DEPTH; i++) tbl_mem[i] = ent(8'h50, 8'h00, 48'h1);
    tbl_mem[0] = ent(8'h03, 8'h01, 48'hA00);
    fire(1'b0, 8'h60, 64'h4545, 64'h0, 1'b0);
    check("R8 miss to illegal", g_target, 64'hA00);
    check("R8 r0", g_r0, 64'h4545);
    check("R5 depth end in_exc", 64'(in_exc), 64'd1);
    ret_pulse();
  endtask

  task automatic t_ext();
    clear_table();
    tbl_mem[0] = ent(8'h03, 8'h01, 48'hB00);
    tbl_mem[1] = ent(8'h70, 8'h80, 48'hC00);
    fire(1'b0, 8'h70, 64'h5555, 64'h0, 1'b1);
    check("R7 user target", g_target, 64'hB00);
    check("R7 user r0", g_r0, 64'h5555);
    ret_pulse();
    fire(1'b0, 8'h70, 64'h5556, 64'h0, 1'b0);
    check("R7 kernel target", g_target, 64'hC00);
    check("R7 kernel no r0", 64'(g_r0we), 64'd0);
  endtask

  task automatic t_user_exc();
    clear_table();
    tbl_mem[0] = ent(8'h02, 8'h01, 48'hD00);
    fire(1'b1, 8'h02, 64'h6666, 64'h0, 1'b1);
    check("R9 kind", 64'(g_kind), 64'd2);
    check("R9 target", g_target, 64'h6666);
    check("R9 r0", g_r0, 64'h6666);
    check("R9 no hang", 64'(hang), 64'd0);
    tbl_mem[0] = ent(8'h02, 8'h03, 48'hD00);
    fire(1'b1, 8'h02, 64'h6667, 64'h0, 1'b1);
    check("R2 user handler", g_target, 64'hD00);
    ret_pulse();
  endtask

  task automatic t_code_norm();
    clear_table();
    tbl_mem[0] = ent(8'h03, 8'h01, 48'hE00);
    fire(1'b1, 8'h09, 64'h7070, 64'h5, 1'b0);
    check("R2 code>3 target", g_target, 64'hE00);
    check("R2 code>3 no r1", 64'(g_r1we), 64'd0);
    ret_pulse();
  endtask

  task automatic t_nested();
    clear_table();
    tbl_mem[0] = ent(8'h00, 8'h01, 48'hF00);
    fire(1'b1, 8'h00, 64'h8000, 64'h0, 1'b0);
    check("R11 first", g_target, 64'hF00);
    fire(1'b1, 8'h00, 64'h8001, 64'h0, 1'b0);
    check("R11 nested kind", 64'(g_kind), 64'd3);
    check("R11 nested no r0", 64'(g_r0we), 64'd0);
    check("R11 nested hang", 64'(hang), 64'd1);
    do_reset();
  endtask

  task automatic t_missing();
    clear_table();
    fire(1'b1, 8'h00, 64'h7777, 64'h0, 1'b0);
    check("R10 kind", 64'(g_kind), 64'd3);
    check("R10 r0", g_r0, 64'h7777);
    repeat (5) @(negedge clk);
    check("R10 hang held", 64'(hang), 64'd1);
    check("R10 ready low", 64'(evt_ready), 64'd0);
    do_reset();
    check("R12 hang cleared", 64'(hang), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_table();
    do_reset();
    t_reset();
    t_int_jump();
    t_div_handler();
    t_page();
    t_priority();
    t_malformed();
    t_null_stop();
    t_depth_miss();
    t_ext();
    t_user_exc();
    t_code_norm();
    t_nested();
    t_missing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule